// File: doc/BRIEF.md
# Dispatch Group Admission Controller

This block sits between a queue of decoded instructions and the scheduler queues of an out-of-order core. In every cycle the queue presents its oldest instructions in slots, slot 0 being the oldest. The block picks the longest run of them, starting at slot 0, that the core can take in that cycle. An instruction is admitted only when all of these hold: the group has room and no static grouping rule forbids it, the reorder buffer has enough free entries, enough rename temporaries remain, the scheduler queue it targets has space, and the load or store queue has space. The block returns the number admitted so that the queue can pop them, and presents a registered dispatch-valid mask one cycle later.

The block keeps its own credit counters for every resource. Each cycle the owner of a resource reports how many entries it released. For each cycle it also records which condition stopped the oldest instruction that could not go, and a histogram of how many instructions went out.

Top module: `dgc_dispatch_ctrl`

## Requirements
- R1: At most DISP_W instructions (default ISSUE_W, which is 2) are admitted per cycle. `disp_valid` is the registered admit mask of the previous cycle, bit i for slot i.
- R2: Admission is in program order. The admitted slots always form a prefix starting at slot 0, and a blocked slot blocks every younger slot in that cycle.
- R3: An instruction needs `in_uops` free reorder-buffer entries (ROB_SIZE = 8 at reset), counted together with the older slots admitted in the same cycle. If too few remain, it is blocked.
- R4: An instruction needs one rename temporary per destination (`in_dst`), from a pool of TMP_SIZE = 6. If TMP_SIZE is 0, the pool is unlimited and never blocks.
- R5: An instruction that is not zero-latency takes one entry of scheduler `in_sid` (SCHED_DEPTH = 4 each). It is blocked when that queue has no free entry left.
- R6: A zero-latency instruction (`in_zlat`) takes no scheduler entry and is admitted even when its scheduler is full. It still takes its reorder-buffer entries.
- R7: A load (`in_load`) takes a load-queue entry (LQ_SIZE = 2) and a store (`in_store`) takes a store-queue entry (SQ_SIZE = 2). Each is blocked when its queue is full.
- R8: An instruction flagged `in_solo` must dispatch alone. It blocks when it is not in slot 0. When it is in slot 0, it blocks every younger slot.
- R9: In a cycle where a valid instruction is blocked, exactly one stall counter increments. The counter is picked by the first failing check of the oldest blocked instruction, in the order group, reorder buffer, temporaries, scheduler, load queue, store queue. When no valid instruction is blocked, no counter moves.
- R10: Entries released in a cycle, through the `*_release` inputs, become available for admission only in the next cycle.
- R11: In every cycle out of reset, exactly one histogram bin increments: the bin `disp_hist[n]`, where n is the number of instructions admitted in that cycle.
- R12: After reset, `disp_valid`, all stall counters and all histogram bins are zero, and all credits are at full capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DISP_W | Slot holds an instruction (thermometer from slot 0) |
| in_uops | input | DISP_W x UOP_W | Micro-op count per slot |
| in_sid | input | DISP_W x SID_W | Target scheduler per slot |
| in_dst | input | DISP_W x DST_W | Register destination count per slot |
| in_zlat | input | DISP_W | Zero-latency flag per slot |
| in_load | input | DISP_W | Load flag per slot |
| in_store | input | DISP_W | Store flag per slot |
| in_solo | input | DISP_W | Must-dispatch-alone flag per slot |
| rob_release | input | CRD_W | Reorder-buffer entries freed this cycle |
| tmp_release | input | CRD_W | Rename temporaries freed this cycle |
| lq_release | input | CRD_W | Load-queue entries freed this cycle |
| sq_release | input | CRD_W | Store-queue entries freed this cycle |
| sch_release | input | NSCHED x CRD_W | Scheduler entries freed this cycle, per scheduler |
| accept_cnt | output | clog2(DISP_W+1) | Number of slots admitted this cycle (combinational) |
| disp_valid | output | DISP_W | Registered admit mask |
| stall_rob | output | CNT_W | Cycles blocked on reorder-buffer entries |
| stall_tmp | output | CNT_W | Cycles blocked on rename temporaries |
| stall_sched | output | CNT_W | Cycles blocked on a full scheduler queue |
| stall_lq | output | CNT_W | Cycles blocked on a full load queue |
| stall_sq | output | CNT_W | Cycles blocked on a full store queue |
| stall_group | output | CNT_W | Cycles blocked by a grouping rule |
| disp_hist | output | (DISP_W+1) x CNT_W | Cycle histogram of admitted count |

## Verification
The assertions assume well-formed inputs. Valid slots are contiguous from slot 0, every instruction has at least one micro-op, every scheduler index is in range, and no owner releases more entries than it holds. The capacity bounds checked on the credits rely on that last point. The directed stimulus uses only contiguous slots, micro-op counts of one to three and scheduler indices 0 to 2. It drives a release only after the matching entries have been taken, so every resource stays within its bounds.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  // Blocking reasons; numeric order is also the check priority.
  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_GROUP = 3'd1,
    CZ_ROB   = 3'd2,
    CZ_TMP   = 3'd3,
    CZ_SCHED = 3'd4,
    CZ_LQ    = 3'd5,
    CZ_SQ    = 3'd6
  } stall_e;

  localparam int NUM_CAUSES = 6;
endpackage

// File: rtl/dgc_credit.sv
module dgc_credit #(
  parameter int CAP   = 8,
  parameter int CRD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CRD_W-1:0] take,
  input  logic [CRD_W-1:0] give,
  output logic [CRD_W-1:0] avail
);
  generate
    if (CAP == 0) begin : g_unlimited
      logic unused_ok;
      assign unused_ok = ^{clk, rst, take, give};
      assign avail = '0;
    end else begin : g_counted
      logic [CRD_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= CRD_W'(CAP);
        else     cnt_q <= cnt_q - take + give;
      end
      assign avail = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/dgc_admit.sv
module dgc_admit import dgc_pkg::*; #(
  parameter int W       = 2,
  parameter int NSCHED  = 3,
  parameter int SID_W   = 2,
  parameter int UOP_W   = 2,
  parameter int DST_W   = 2,
  parameter int CRD_W   = 8,
  parameter int SUM_W   = 12,
  parameter bit TMP_UNL = 1'b0,
  parameter bit LQ_UNL  = 1'b0,
  parameter bit SQ_UNL  = 1'b0
) (
  input  logic [W-1:0]                  valid,
  input  logic [W-1:0][UOP_W-1:0]       uops,
  input  logic [W-1:0][SID_W-1:0]       sid,
  input  logic [W-1:0][DST_W-1:0]       dst,
  input  logic [W-1:0]                  zlat,
  input  logic [W-1:0]                  ld,
  input  logic [W-1:0]                  st,
  input  logic [W-1:0]                  solo,
  input  logic [CRD_W-1:0]              rob_avail,
  input  logic [CRD_W-1:0]              tmp_avail,
  input  logic [CRD_W-1:0]              lq_avail,
  input  logic [CRD_W-1:0]              sq_avail,
  input  logic [NSCHED-1:0][CRD_W-1:0]  sch_avail,
  output logic [W-1:0]                  mask,
  output stall_e                        cause,
  output logic [CRD_W-1:0]              rob_use,
  output logic [CRD_W-1:0]              tmp_use,
  output logic [CRD_W-1:0]              lq_use,
  output logic [CRD_W-1:0]              sq_use,
  output logic [NSCHED-1:0][CRD_W-1:0]  sch_use
);
  logic [SUM_W-1:0]             rob_s, tmp_s, lq_s, sq_s;
  logic [NSCHED-1:0][SUM_W-1:0] sch_s;
  logic                         go, sch_bad;
  stall_e                       why;

  // Running sums over slots; a slot is judged against the sum up to itself.
  always_comb begin
    rob_s = '0; tmp_s = '0; lq_s = '0; sq_s = '0; sch_s = '0;
    rob_use = '0; tmp_use = '0; lq_use = '0; sq_use = '0; sch_use = '0;
    mask = '0; cause = CZ_NONE; go = 1'b1; sch_bad = 1'b0; why = CZ_NONE;
    for (int i = 0; i < W; i++) begin
      rob_s = rob_s + SUM_W'(uops[i]);
      tmp_s = tmp_s + SUM_W'(dst[i]);
      lq_s  = lq_s + SUM_W'(ld[i]);
      sq_s  = sq_s + SUM_W'(st[i]);
      sch_bad = 1'b0;
      for (int k = 0; k < NSCHED; k++) begin
        if (!zlat[i] && sid[i] == SID_W'(k)) begin
          sch_s[k] = sch_s[k] + SUM_W'(1);
          if (sch_s[k] > SUM_W'(sch_avail[k])) sch_bad = 1'b1;
        end
      end
      if (i > 0 && (solo[i] || solo[0]))                    why = CZ_GROUP;
      else if (rob_s > SUM_W'(rob_avail))                   why = CZ_ROB;
      else if (!TMP_UNL && tmp_s > SUM_W'(tmp_avail))       why = CZ_TMP;
      else if (sch_bad)                                     why = CZ_SCHED;
      else if (!LQ_UNL && ld[i] && lq_s > SUM_W'(lq_avail)) why = CZ_LQ;
      else if (!SQ_UNL && st[i] && sq_s > SUM_W'(sq_avail)) why = CZ_SQ;
      else                                                  why = CZ_NONE;
      if (go && valid[i]) begin
        if (why == CZ_NONE) begin
          mask[i] = 1'b1;
          rob_use = CRD_W'(rob_s);
          tmp_use = CRD_W'(tmp_s);
          lq_use  = CRD_W'(lq_s);
          sq_use  = CRD_W'(sq_s);
          for (int k = 0; k < NSCHED; k++) sch_use[k] = CRD_W'(sch_s[k]);
        end else begin
          cause = why;
          go    = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dgc_stats.sv
module dgc_stats import dgc_pkg::*; #(
  parameter int W     = 2,
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [W-1:0]                    mask,
  input  stall_e                          cause,
  output logic [NUM_CAUSES-1:0][CNT_W-1:0] stall_q,
  output logic [W:0][CNT_W-1:0]           hist_q
);
  logic [AW-1:0] ndisp;
  assign ndisp = AW'($countones(mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= '0;
      hist_q  <= '0;
    end else begin
      for (int c = 0; c < NUM_CAUSES; c++)
        if (cause == stall_e'(c + 1)) stall_q[c] <= stall_q[c] + CNT_W'(1);
      for (int b = 0; b <= W; b++)
        if (ndisp == AW'(b)) hist_q[b] <= hist_q[b] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dgc_dispatch_ctrl.sv
module dgc_dispatch_ctrl import dgc_pkg::*; #(
  parameter int ISSUE_W     = 2,
  parameter int DISP_W      = ISSUE_W,
  parameter int NSCHED      = 3,
  parameter int SCHED_DEPTH = 4,
  parameter int ROB_SIZE    = 8,
  parameter int TMP_SIZE    = 6,
  parameter int LQ_SIZE     = 2,
  parameter int SQ_SIZE     = 2,
  parameter int UOP_W       = 2,
  parameter int DST_W       = 2,
  parameter int SID_W       = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  parameter int CRD_W       = 8,
  parameter int CNT_W       = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [DISP_W-1:0]                in_valid,
  input  logic [DISP_W-1:0][UOP_W-1:0]     in_uops,
  input  logic [DISP_W-1:0][SID_W-1:0]     in_sid,
  input  logic [DISP_W-1:0][DST_W-1:0]     in_dst,
  input  logic [DISP_W-1:0]                in_zlat,
  input  logic [DISP_W-1:0]                in_load,
  input  logic [DISP_W-1:0]                in_store,
  input  logic [DISP_W-1:0]                in_solo,
  input  logic [CRD_W-1:0]                 rob_release,
  input  logic [CRD_W-1:0]                 tmp_release,
  input  logic [CRD_W-1:0]                 lq_release,
  input  logic [CRD_W-1:0]                 sq_release,
  input  logic [NSCHED-1:0][CRD_W-1:0]     sch_release,
  output logic [$clog2(DISP_W+1)-1:0]      accept_cnt,
  output logic [DISP_W-1:0]                disp_valid,
  output logic [CNT_W-1:0]                 stall_rob,
  output logic [CNT_W-1:0]                 stall_tmp,
  output logic [CNT_W-1:0]                 stall_sched,
  output logic [CNT_W-1:0]                 stall_lq,
  output logic [CNT_W-1:0]                 stall_sq,
  output logic [CNT_W-1:0]                 stall_group,
  output logic [DISP_W:0][CNT_W-1:0]       disp_hist
);
  localparam int AW    = $clog2(DISP_W + 1);
  localparam int SUM_W = CRD_W + UOP_W + AW;

  logic [CRD_W-1:0]                rob_avail, tmp_avail, lq_avail, sq_avail;
  logic [CRD_W-1:0]                rob_use, tmp_use, lq_use, sq_use;
  logic [NSCHED-1:0][CRD_W-1:0]    sch_avail, sch_use;
  logic [DISP_W-1:0]               acc_mask;
  stall_e                          cause;
  logic [NUM_CAUSES-1:0][CNT_W-1:0] stall_q;

  dgc_credit #(.CAP(ROB_SIZE), .CRD_W(CRD_W)) u_rob (
    .clk(clk), .rst(rst), .take(rob_use), .give(rob_release), .avail(rob_avail));
  dgc_credit #(.CAP(TMP_SIZE), .CRD_W(CRD_W)) u_tmp (
    .clk(clk), .rst(rst), .take(tmp_use), .give(tmp_release), .avail(tmp_avail));
  dgc_credit #(.CAP(LQ_SIZE), .CRD_W(CRD_W)) u_lq (
    .clk(clk), .rst(rst), .take(lq_use), .give(lq_release), .avail(lq_avail));
  dgc_credit #(.CAP(SQ_SIZE), .CRD_W(CRD_W)) u_sq (
    .clk(clk), .rst(rst), .take(sq_use), .give(sq_release), .avail(sq_avail));

  generate
    for (genvar k = 0; k < NSCHED; k++) begin : g_sched
      dgc_credit #(.CAP(SCHED_DEPTH), .CRD_W(CRD_W)) u_sch (
        .clk(clk), .rst(rst), .take(sch_use[k]), .give(sch_release[k]),
        .avail(sch_avail[k]));
    end
  endgenerate

  dgc_admit #(
    .W(DISP_W), .NSCHED(NSCHED), .SID_W(SID_W), .UOP_W(UOP_W), .DST_W(DST_W),
    .CRD_W(CRD_W), .SUM_W(SUM_W),
    .TMP_UNL(TMP_SIZE == 0), .LQ_UNL(LQ_SIZE == 0), .SQ_UNL(SQ_SIZE == 0)
  ) u_admit (
    .valid(in_valid), .uops(in_uops), .sid(in_sid), .dst(in_dst),
    .zlat(in_zlat), .ld(in_load), .st(in_store), .solo(in_solo),
    .rob_avail(rob_avail), .tmp_avail(tmp_avail), .lq_avail(lq_avail),
    .sq_avail(sq_avail), .sch_avail(sch_avail),
    .mask(acc_mask), .cause(cause),
    .rob_use(rob_use), .tmp_use(tmp_use), .lq_use(lq_use), .sq_use(sq_use),
    .sch_use(sch_use)
  );

  dgc_stats #(.W(DISP_W), .CNT_W(CNT_W), .AW(AW)) u_stats (
    .clk(clk), .rst(rst), .mask(acc_mask), .cause(cause),
    .stall_q(stall_q), .hist_q(disp_hist));

  assign accept_cnt  = AW'($countones(acc_mask));
  assign stall_group = stall_q[0];
  assign stall_rob   = stall_q[1];
  assign stall_tmp   = stall_q[2];
  assign stall_sched = stall_q[3];
  assign stall_lq    = stall_q[4];
  assign stall_sq    = stall_q[5];

  always_ff @(posedge clk) begin
    if (rst) disp_valid <= '0;
    else     disp_valid <= acc_mask;
  end
endmodule

// File: rtl/dgc_dispatch_ctrl_chk.sv
module dgc_dispatch_ctrl_chk #(
  parameter int W           = 2,
  parameter int NSCHED      = 3,
  parameter int CRD_W       = 8,
  parameter int CNT_W       = 16,
  parameter int ROB_SIZE    = 8,
  parameter int SCHED_DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic [W-1:0]                    in_valid,
  input logic [W-1:0]                    acc_mask,
  input logic [CRD_W-1:0]                rob_avail,
  input logic [NSCHED-1:0][CRD_W-1:0]    sch_avail,
  input logic [5:0][CNT_W-1:0]           stall_q,
  input logic [W:0][CNT_W-1:0]           disp_hist
);
  logic                  armed;
  logic [5:0][CNT_W-1:0] stall_d;
  logic [W:0][CNT_W-1:0] hist_d;
  logic [5:0]            s_chg;
  logic [W:0]            h_chg;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
    stall_d <= stall_q;
    hist_d  <= disp_hist;
  end

  always_comb begin
    for (int c = 0; c < 6; c++) s_chg[c] = (stall_q[c] != stall_d[c]);
    for (int b = 0; b <= W; b++) h_chg[b] = (disp_hist[b] != hist_d[b]);
  end

  // Input assumption for R2: valid slots are contiguous from slot 0.
  a_in_thermo_r2: assert property (@(posedge clk) disable iff (rst)
    ((in_valid + W'(1)) & in_valid) == '0);

  p_prefix_r2: assert property (@(posedge clk) disable iff (rst)
    (((acc_mask + W'(1)) & acc_mask) == '0) && ((acc_mask & ~in_valid) == '0));

  p_rob_cap_r3: assert property (@(posedge clk) disable iff (rst)
    rob_avail <= CRD_W'(ROB_SIZE));

  generate
    for (genvar k = 0; k < NSCHED; k++) begin : g_cap
      p_sched_cap_r5: assert property (@(posedge clk) disable iff (rst)
        sch_avail[k] <= CRD_W'(SCHED_DEPTH));
    end
  endgenerate

  p_one_cause_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    $onehot0(s_chg));

  p_hist_step_r11: assert property (@(posedge clk) disable iff (rst || !armed)
    $countones(h_chg) == 1);
endmodule

bind dgc_dispatch_ctrl dgc_dispatch_ctrl_chk #(
  .W(DISP_W), .NSCHED(NSCHED), .CRD_W(CRD_W), .CNT_W(CNT_W),
  .ROB_SIZE(ROB_SIZE), .SCHED_DEPTH(SCHED_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .acc_mask(acc_mask),
  .rob_avail(rob_avail), .sch_avail(sch_avail), .stall_q(stall_q),
  .disp_hist(disp_hist)
);

// File: tb/test_dgc_dispatch_ctrl.sv
`timescale 1ns/1ps
module test_dgc_dispatch_ctrl;
  localparam int W = 2;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]      in_valid, in_zlat, in_load, in_store, in_solo;
  logic [W-1:0][1:0] in_uops, in_sid, in_dst;
  logic [7:0]        rob_rel, tmp_rel, lq_rel, sq_rel;
  logic [2:0][7:0]   sch_rel;
  logic [1:0]        acc, u_acc;
  logic [W-1:0]      dv, u_dv;
  logic [NW-1:0]     s_rob, s_tmp, s_sch, s_lq, s_sq, s_grp;
  logic [NW-1:0]     u_rob, u_tmp, u_sch, u_lq, u_sq, u_grp;
  logic [W:0][NW-1:0] hist, u_hist;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dgc_dispatch_ctrl i_dgc_dispatch_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_sid(in_sid),
    .in_dst(in_dst), .in_zlat(in_zlat), .in_load(in_load), .in_store(in_store),
    .in_solo(in_solo), .rob_release(rob_rel), .tmp_release(tmp_rel),
    .lq_release(lq_rel), .sq_release(sq_rel), .sch_release(sch_rel),
    .accept_cnt(acc), .disp_valid(dv), .stall_rob(s_rob), .stall_tmp(s_tmp),
    .stall_sched(s_sch), .stall_lq(s_lq), .stall_sq(s_sq), .stall_group(s_grp),
    .disp_hist(hist));

  dgc_dispatch_ctrl #(.TMP_SIZE(0)) i_dgc_dispatch_ctrl_unl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_sid(in_sid),
    .in_dst(in_dst), .in_zlat(in_zlat), .in_load(in_load), .in_store(in_store),
    .in_solo(in_solo), .rob_release(rob_rel), .tmp_release(tmp_rel),
    .lq_release(lq_rel), .sq_release(sq_rel), .sch_release(sch_rel),
    .accept_cnt(u_acc), .disp_valid(u_dv), .stall_rob(u_rob), .stall_tmp(u_tmp),
    .stall_sched(u_sch), .stall_lq(u_lq), .stall_sq(u_sq), .stall_group(u_grp),
    .disp_hist(u_hist));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    in_valid = '0; in_zlat = '0; in_load = '0; in_store = '0; in_solo = '0;
    in_uops = '0; in_sid = '0; in_dst = '0;
    rob_rel = '0; tmp_rel = '0; lq_rel = '0; sq_rel = '0; sch_rel = '0;
  endtask

  task automatic put(int s, int u, int sid, int d, bit z, bit l, bit st, bit so);
    in_valid[s] = 1'b1; in_uops[s] = 2'(u); in_sid[s] = 2'(sid); in_dst[s] = 2'(d);
    in_zlat[s] = z; in_load[s] = l; in_store[s] = st; in_solo[s] = so;
  endtask

  // Check the admit count mid-cycle, commit at the edge, return at the next negedge.
  task automatic step(int exp_acc, string req);
    #1;
    chk(req, int'(acc), exp_acc);
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 disp_valid", int'(dv), 0);
    chk("R12 stall sum", int'(s_rob + s_tmp + s_sch + s_lq + s_sq + s_grp), 0);
    chk("R12 hist sum", int'(hist[0] + hist[1] + hist[2]), 0);
    #1 chk("R12 idle accept", int'(acc), 0);
  endtask

  task automatic t_width();
    do_reset();
    put(0, 1, 0, 1, 0, 0, 0, 0); put(1, 1, 1, 1, 0, 0, 0, 0);
    step(2, "R1 full group");
    chk("R1 disp_valid", int'(dv), 3);
    chk("R11 hist[2]", int'(hist[2]), 1);
    step(0, "R1 idle");
    chk("R1 disp_valid idle", int'(dv), 0);
    chk("R11 hist[0]", int'(hist[0]), 1);
  endtask

  task automatic t_rob();
    do_reset();
    put(0, 3, 0, 0, 0, 0, 0, 0); put(1, 3, 1, 0, 0, 0, 0, 0);
    step(2, "R3 six of eight");
    put(0, 3, 0, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 0);
    step(0, "R2 younger held behind blocked oldest");
    chk("R3 stall_rob", int'(s_rob), 1);
    chk("R2 disp_valid", int'(dv), 0);
    put(0, 3, 0, 0, 0, 0, 0, 0); rob_rel = 8'd3;
    step(0, "R10 release not usable same cycle");
    chk("R10 stall_rob", int'(s_rob), 2);
    put(0, 3, 0, 0, 0, 0, 0, 0);
    step(1, "R10 release usable next cycle");
    chk("R10 stall_rob unchanged", int'(s_rob), 2);
  endtask

  task automatic t_tmp();
    do_reset();
    put(0, 1, 0, 3, 0, 0, 0, 0); put(1, 1, 1, 3, 0, 0, 0, 0);
    step(2, "R4 six temporaries");
    put(0, 1, 2, 1, 0, 0, 0, 0);
    #1 chk("R4 unlimited pool admits", int'(u_acc), 1);
    step(0, "R4 pool empty");
    chk("R4 stall_tmp", int'(s_tmp), 1);
    put(0, 1, 2, 0, 0, 0, 0, 0);
    step(1, "R4 no destination needs no temporary");
  endtask

  task automatic t_sched();
    do_reset();
    put(0, 1, 1, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 0);
    step(2, "R5 fill sched1 a");
    put(0, 1, 1, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 0);
    step(2, "R5 fill sched1 b");
    put(0, 1, 0, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 1);
    step(1, "R9 group checked before scheduler");
    chk("R9 stall_group", int'(s_grp), 1);
    chk("R9 stall_sched untouched", int'(s_sch), 0);
    put(0, 1, 0, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, "R5 sched1 full");
    chk("R5 stall_sched", int'(s_sch), 1);
    put(0, 2, 1, 0, 1, 0, 0, 0);
    step(1, "R6 zero-latency skips full scheduler");
    put(0, 1, 1, 0, 1, 0, 0, 0);
    step(0, "R6 zero-latency still needs ROB");
    chk("R6 stall_rob", int'(s_rob), 1);
    chk("R6 stall_sched unchanged", int'(s_sch), 1);
  endtask

  task automatic t_lsq();
    do_reset();
    put(0, 1, 0, 0, 0, 1, 0, 0); put(1, 1, 0, 0, 0, 1, 0, 0);
    step(2, "R7 two loads");
    put(0, 1, 2, 0, 0, 0, 1, 0); put(1, 1, 0, 0, 0, 1, 0, 0);
    step(1, "R7 load queue full");
    chk("R7 stall_lq", int'(s_lq), 1);
    put(0, 1, 2, 0, 0, 0, 1, 0); put(1, 1, 2, 0, 0, 0, 1, 0);
    step(1, "R7 store queue full");
    chk("R7 stall_sq", int'(s_sq), 1);
    chk("R9 stall_lq unchanged", int'(s_lq), 1);
  endtask

  task automatic t_solo();
    do_reset();
    put(0, 1, 0, 0, 0, 0, 0, 0); put(1, 1, 1, 0, 0, 0, 0, 1);
    step(1, "R8 solo in slot 1");
    chk("R8 stall_group a", int'(s_grp), 1);
    put(0, 1, 0, 0, 0, 0, 0, 1); put(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, "R8 solo in slot 0 blocks younger");
    chk("R8 stall_group b", int'(s_grp), 2);
    put(0, 1, 0, 0, 0, 0, 0, 1);
    step(1, "R8 solo alone");
    chk("R9 no blocked slot no count", int'(s_grp), 2);
    chk("R11 hist[1]", int'(hist[1]), 3);
    step(0, "R11 idle");
    chk("R11 total cycles", int'(hist[0] + hist[1] + hist[2]), 4);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    t_reset();
    t_width();
    t_rob();
    t_tmp();
    t_sched();
    t_lsq();
    t_solo();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule